// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register File

This block is the host-visible register layer of a two-channel asynchronous serial controller. The host reaches it over a byte-wide bus that has a read strobe and a write strobe. It turns host writes into per-channel control: receiver and transmitter enables, one-cycle reset pulses toward the data path, a break-line request, and decoded character-format, FIFO and rate-select fields. It also assembles a per-channel status byte from the data path's ready, empty and error signals.

Each channel has a single command register. The low four bits of that register enable or disable the receiver and transmitter. The high nibble carries an action code, and both parts can arrive in the same write. The three mode registers share one address. A pointer chooses which of them a write lands in. Pointer commands set the pointer, and each write to the mode address advances it. This lets a driver load the whole character format with consecutive writes to one address.

The serial shifters, the rate generator and the FIFOs sit outside this block. The block sees them only through its ready, empty, error and receive-data inputs, and it drives them through its enable, reset, format and holding-register strobe outputs.

Top module: `duart_regfile`

## Requirements
- R1: The address is split into a channel field and a local offset, and channel c occupies addresses c*8 to c*8+7. Offset 0 is the mode register. Offset 1 writes the rate select and reads the status byte. Offset 2 is the command register. Offset 3 writes the transmit holding register and reads the receive data. An access to one channel leaves every other channel unchanged.
- R2: In a command write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If a write sets both bits of a pair, the disable wins. The new state shows one cycle after the write.
- R3: Command code 6 in bits [7:4] raises the break request and code 7 lowers it.
- R4: Reset leaves the mode pointer on MR1. Code 1 points it at MR1 and code 0xB points it at MR0. Each write to offset 0 loads the register under the pointer and then advances the pointer from MR0 to MR1 and from MR1 to MR2. At MR2 the pointer stays put. A read of offset 0 returns the register under the pointer and does not move the pointer.
- R5: MR1 bits [1:0] give the character length as 5 plus the code. Parity is enabled when MR1 bit 4 is 0, and MR1 bit 2 then selects odd parity. Code 4 in bits [4:2] means no parity.
- R6: MR2 bit 3 selects two stop bits, so a low nibble of 0xF gives two stop bits and a low nibble of 7 gives one.
- R7: MR0 bits [2:0] select the rate-table variant, bit 3 enables the extended FIFO, and bit 4 selects the half-level transmit threshold.
- R8: A rate-select write puts the receive rate code in bits [7:4] and the transmit rate code in bits [3:0].
- R9: The status byte has this layout: bit 0 receive ready, bit 1 FIFO full, bit 2 transmit ready, bit 3 transmitter empty, bit 4 overrun, bit 5 parity error, bit 6 framing error, bit 7 received break. Bit 2 reads 1 only while the transmitter is enabled.
- R10: The four error bits are sticky, and each is set by a one-cycle event input. Code 4 clears all four. Code 5 clears only the break bit. An event that arrives in the same cycle as a clear leaves its bit set.
- R11: Code 2 produces a one-cycle receiver reset pulse. During that cycle the receive-ready status bit reads 0.
- R12: Code 3 produces a one-cycle transmitter reset pulse and disables the transmitter, even when the same write sets the transmitter enable bit.
- R13: A write to offset 3 produces a one-cycle holding-register strobe in the next cycle, carrying the written byte. A read of offset 3 returns that channel's receive data and raises that channel's receive-read strobe in the same cycle.
- R14: After reset both enables are off, break is off, and the mode and rate registers read zero, so the format is 5 bits with even parity and one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Register address: channel field above a 3-bit offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| rx_data_i | input | 8*NCH | Receive data per channel |
| rx_rdy_i | input | NCH | Receive data available |
| fifo_full_i | input | NCH | Receive FIFO full |
| tx_rdy_i | input | NCH | Transmit holding space free |
| tx_empty_i | input | NCH | Transmitter fully drained |
| ovr_evt_i | input | NCH | Overrun event pulse |
| par_evt_i | input | NCH | Parity error event pulse |
| frm_evt_i | input | NCH | Framing error event pulse |
| brk_evt_i | input | NCH | Received-break event pulse |
| rx_en_o | output | NCH | Receiver enable |
| tx_en_o | output | NCH | Transmitter enable |
| rx_rst_o | output | NCH | Receiver reset pulse |
| tx_rst_o | output | NCH | Transmitter reset pulse |
| break_o | output | NCH | Transmit break request |
| data_bits_o | output | 4*NCH | Character length, 5 to 8 |
| par_en_o | output | NCH | Parity enabled |
| par_odd_o | output | NCH | Odd parity selected |
| two_stop_o | output | NCH | Two stop bits |
| fifo_ext_o | output | NCH | Extended FIFO enable |
| tx_half_o | output | NCH | Half-level transmit threshold |
| baud_var_o | output | 3*NCH | Rate-table variant |
| rx_rate_o | output | 4*NCH | Receive rate code |
| tx_rate_o | output | 4*NCH | Transmit rate code |
| thr_wr_o | output | NCH | Transmit holding write strobe |
| thr_data_o | output | 8*NCH | Transmit holding data |
| rhr_rd_o | output | NCH | Receive data read strobe |

## Verification
Every registered result, which covers the enables, break, the mode, rate and error registers and the reset and holding-register strobes, is due one clock after the edge that samples the write or event. The bench drives stimulus on the falling edge and checks on the next falling edge, so each value is read after exactly one rising edge. Read data and the receive-read strobe are combinational, so the bench compares them a short delay after it sets the address within the same cycle. Pulse outputs are checked twice: once in the cycle they are due and again one cycle later, when they must have dropped.

// File: rtl/duart_pkg.sv
package duart_pkg;
  typedef enum logic [1:0] {PTR_MR0 = 2'd0, PTR_MR1 = 2'd1, PTR_MR2 = 2'd2} mr_ptr_e;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_RATE = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;
  localparam logic [2:0] OFS_DATA = 3'd3;

  localparam logic [3:0] CMD_PTR1   = 4'h1;
  localparam logic [3:0] CMD_RXRST  = 4'h2;
  localparam logic [3:0] CMD_TXRST  = 4'h3;
  localparam logic [3:0] CMD_ERRCLR = 4'h4;
  localparam logic [3:0] CMD_BRKCLR = 4'h5;
  localparam logic [3:0] CMD_BRKON  = 4'h6;
  localparam logic [3:0] CMD_BRKOFF = 4'h7;
  localparam logic [3:0] CMD_PTR0   = 4'hB;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr1;
    logic ptr0;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_clr;
    logic brk_on;
    logic brk_off;
  } cmd_act_t;
endpackage

// File: rtl/duart_cmd_dec.sv
module duart_cmd_dec
  import duart_pkg::*;
(
  input  logic       vld_i,
  input  logic [7:0] cmd_i,
  output cmd_act_t   act_o
);
  always_comb begin
    act_o        = '0;
    act_o.rx_on  = vld_i & cmd_i[0];
    act_o.rx_off = vld_i & cmd_i[1];
    act_o.tx_on  = vld_i & cmd_i[2];
    act_o.tx_off = vld_i & cmd_i[3];
    if (vld_i) begin
      case (cmd_i[7:4])
        CMD_PTR1:   act_o.ptr1    = 1'b1;
        CMD_PTR0:   act_o.ptr0    = 1'b1;
        CMD_RXRST:  act_o.rx_rst  = 1'b1;
        CMD_TXRST:  act_o.tx_rst  = 1'b1;
        CMD_ERRCLR: act_o.err_clr = 1'b1;
        CMD_BRKCLR: act_o.brk_clr = 1'b1;
        CMD_BRKON:  act_o.brk_on  = 1'b1;
        CMD_BRKOFF: act_o.brk_off = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/duart_status.sv
module duart_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] evt_i,      // {brk, frm, par, ovr}
  input  logic       err_clr_i,
  input  logic       brk_clr_i,
  input  logic       rx_rdy_i,
  input  logic       rx_mask_i,
  input  logic       fifo_full_i,
  input  logic       tx_rdy_i,
  input  logic       tx_en_i,
  input  logic       tx_empty_i,
  output logic [7:0] status_o
);
  logic [3:0] err_q;
  logic [3:0] clr_mask;

  always_comb begin
    clr_mask = 4'h0;
    if (err_clr_i)      clr_mask = 4'hF;
    else if (brk_clr_i) clr_mask = 4'h8;
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_q & ~clr_mask) | evt_i;
  end

  assign status_o = {err_q, tx_empty_i, tx_rdy_i & tx_en_i, fifo_full_i, rx_rdy_i & ~rx_mask_i};
endmodule

// File: rtl/duart_chan.sv
module duart_chan
  import duart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] ofs_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] rx_data_i,
  input  logic       rx_rdy_i,
  input  logic       fifo_full_i,
  input  logic       tx_rdy_i,
  input  logic       tx_empty_i,
  input  logic [3:0] evt_i,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       rx_rst_o,
  output logic       tx_rst_o,
  output logic       break_o,
  output logic [3:0] data_bits_o,
  output logic       par_en_o,
  output logic       par_odd_o,
  output logic       two_stop_o,
  output logic       fifo_ext_o,
  output logic       tx_half_o,
  output logic [2:0] baud_var_o,
  output logic [3:0] rx_rate_o,
  output logic [3:0] tx_rate_o,
  output logic       thr_wr_o,
  output logic [7:0] thr_data_o,
  output logic       rhr_rd_o
);
  cmd_act_t   act;
  mr_ptr_e    ptr_q;
  logic [7:0] mr0_q, mr1_q, mr2_q, rate_q, thr_q, status;
  logic       rx_en_q, tx_en_q, brk_q, rx_rst_q, tx_rst_q, thr_wr_q;
  logic       wr_mode, wr_rate, wr_data;

  assign wr_mode = wr_i && ofs_i == OFS_MODE;
  assign wr_rate = wr_i && ofs_i == OFS_RATE;
  assign wr_data = wr_i && ofs_i == OFS_DATA;

  duart_cmd_dec u_dec (
    .vld_i (wr_i && ofs_i == OFS_CMD),
    .cmd_i (wdata_i),
    .act_o (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      brk_q    <= 1'b0;
      ptr_q    <= PTR_MR1;
      mr0_q    <= '0;
      mr1_q    <= '0;
      mr2_q    <= '0;
      rate_q   <= '0;
      thr_q    <= '0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
      thr_wr_q <= 1'b0;
    end else begin
      // disable beats enable; transmitter reset beats both
      if (act.rx_off)                   rx_en_q <= 1'b0;
      else if (act.rx_on)               rx_en_q <= 1'b1;
      if (act.tx_off || act.tx_rst)     tx_en_q <= 1'b0;
      else if (act.tx_on)               tx_en_q <= 1'b1;
      if (act.brk_on)                   brk_q <= 1'b1;
      else if (act.brk_off)             brk_q <= 1'b0;
      if (act.ptr1)                     ptr_q <= PTR_MR1;
      else if (act.ptr0)                ptr_q <= PTR_MR0;
      else if (wr_mode) begin
        case (ptr_q)
          PTR_MR0: begin mr0_q <= wdata_i; ptr_q <= PTR_MR1; end
          PTR_MR1: begin mr1_q <= wdata_i; ptr_q <= PTR_MR2; end
          default: mr2_q <= wdata_i;
        endcase
      end
      if (wr_rate) rate_q <= wdata_i;
      if (wr_data) thr_q  <= wdata_i;
      rx_rst_q <= act.rx_rst;
      tx_rst_q <= act.tx_rst;
      thr_wr_q <= wr_data;
    end
  end

  duart_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .err_clr_i   (act.err_clr),
    .brk_clr_i   (act.brk_clr),
    .rx_rdy_i    (rx_rdy_i),
    .rx_mask_i   (rx_rst_q),
    .fifo_full_i (fifo_full_i),
    .tx_rdy_i    (tx_rdy_i),
    .tx_en_i     (tx_en_q),
    .tx_empty_i  (tx_empty_i),
    .status_o    (status)
  );

  always_comb begin
    case (ofs_i)
      OFS_MODE: rdata_o = (ptr_q == PTR_MR0) ? mr0_q : (ptr_q == PTR_MR1) ? mr1_q : mr2_q;
      OFS_RATE: rdata_o = status;
      OFS_DATA: rdata_o = rx_data_i;
      default:  rdata_o = 8'h00;
    endcase
  end

  assign rhr_rd_o    = rd_i && ofs_i == OFS_DATA;
  assign rx_en_o     = rx_en_q;
  assign tx_en_o     = tx_en_q;
  assign rx_rst_o    = rx_rst_q;
  assign tx_rst_o    = tx_rst_q;
  assign break_o     = brk_q;
  assign data_bits_o = 4'd5 + {2'b00, mr1_q[1:0]};
  assign par_en_o    = ~mr1_q[4];
  assign par_odd_o   = mr1_q[2];
  assign two_stop_o  = mr2_q[3];
  assign baud_var_o  = mr0_q[2:0];
  assign fifo_ext_o  = mr0_q[3];
  assign tx_half_o   = mr0_q[4];
  assign rx_rate_o   = rate_q[7:4];
  assign tx_rate_o   = rate_q[3:0];
  assign thr_wr_o    = thr_wr_q;
  assign thr_data_o  = thr_q;
endmodule

// File: rtl/duart_regfile.sv
module duart_regfile #(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH) + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [8*NCH-1:0] rx_data_i,
  input  logic [NCH-1:0]   rx_rdy_i,
  input  logic [NCH-1:0]   fifo_full_i,
  input  logic [NCH-1:0]   tx_rdy_i,
  input  logic [NCH-1:0]   tx_empty_i,
  input  logic [NCH-1:0]   ovr_evt_i,
  input  logic [NCH-1:0]   par_evt_i,
  input  logic [NCH-1:0]   frm_evt_i,
  input  logic [NCH-1:0]   brk_evt_i,
  output logic [NCH-1:0]   rx_en_o,
  output logic [NCH-1:0]   tx_en_o,
  output logic [NCH-1:0]   rx_rst_o,
  output logic [NCH-1:0]   tx_rst_o,
  output logic [NCH-1:0]   break_o,
  output logic [4*NCH-1:0] data_bits_o,
  output logic [NCH-1:0]   par_en_o,
  output logic [NCH-1:0]   par_odd_o,
  output logic [NCH-1:0]   two_stop_o,
  output logic [NCH-1:0]   fifo_ext_o,
  output logic [NCH-1:0]   tx_half_o,
  output logic [3*NCH-1:0] baud_var_o,
  output logic [4*NCH-1:0] rx_rate_o,
  output logic [4*NCH-1:0] tx_rate_o,
  output logic [NCH-1:0]   thr_wr_o,
  output logic [8*NCH-1:0] thr_data_o,
  output logic [NCH-1:0]   rhr_rd_o
);
  localparam int CHW = AW - 3;

  logic [CHW-1:0] ch_sel;
  logic [7:0]     rd_vec [NCH];

  assign ch_sel = addr_i[AW-1:3];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (ch_sel == CHW'(i));

    duart_chan u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_i & hit),
      .rd_i        (rd_i & hit),
      .ofs_i       (addr_i[2:0]),
      .wdata_i     (wdata_i),
      .rdata_o     (rd_vec[i]),
      .rx_data_i   (rx_data_i[i*8 +: 8]),
      .rx_rdy_i    (rx_rdy_i[i]),
      .fifo_full_i (fifo_full_i[i]),
      .tx_rdy_i    (tx_rdy_i[i]),
      .tx_empty_i  (tx_empty_i[i]),
      .evt_i       ({brk_evt_i[i], frm_evt_i[i], par_evt_i[i], ovr_evt_i[i]}),
      .rx_en_o     (rx_en_o[i]),
      .tx_en_o     (tx_en_o[i]),
      .rx_rst_o    (rx_rst_o[i]),
      .tx_rst_o    (tx_rst_o[i]),
      .break_o     (break_o[i]),
      .data_bits_o (data_bits_o[i*4 +: 4]),
      .par_en_o    (par_en_o[i]),
      .par_odd_o   (par_odd_o[i]),
      .two_stop_o  (two_stop_o[i]),
      .fifo_ext_o  (fifo_ext_o[i]),
      .tx_half_o   (tx_half_o[i]),
      .baud_var_o  (baud_var_o[i*3 +: 3]),
      .rx_rate_o   (rx_rate_o[i*4 +: 4]),
      .tx_rate_o   (tx_rate_o[i*4 +: 4]),
      .thr_wr_o    (thr_wr_o[i]),
      .thr_data_o  (thr_data_o[i*8 +: 8]),
      .rhr_rd_o    (rhr_rd_o[i])
    );
  end

  assign rdata_o = rd_vec[ch_sel];
endmodule

// File: rtl/duart_regfile_chk.sv
module duart_regfile_chk #(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH) + 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_i,
  input logic [7:0]       wdata_i,
  input logic [NCH-1:0]   rx_en_o,
  input logic [NCH-1:0]   tx_en_o,
  input logic [NCH-1:0]   rx_rst_o,
  input logic [NCH-1:0]   tx_rst_o,
  input logic [NCH-1:0]   break_o,
  input logic [NCH-1:0]   thr_wr_o,
  input logic [8*NCH-1:0] thr_data_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam logic [AW-1:0] CMD_A = AW'(i * 8 + 2);
    localparam logic [AW-1:0] THR_A = AW'(i * 8 + 3);

    // R2
    rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == CMD_A && wdata_i[1]) |=> !rx_en_o[i]);

    // R3
    brk_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == CMD_A && wdata_i[7:4] == 4'h6) |=> break_o[i]);

    // R11
    rx_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_rst_o[i] |-> $past(wr_i && addr_i == CMD_A && wdata_i[7:4] == 4'h2));

    // R12
    tx_rst_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_rst_o[i] |-> !tx_en_o[i]);

    // R13
    thr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_wr_o[i] |-> ($past(wr_i && addr_i == THR_A) && thr_data_o[i*8 +: 8] == $past(wdata_i)));
  end
endmodule

bind duart_regfile duart_regfile_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rx_en_o    (rx_en_o),
  .tx_en_o    (tx_en_o),
  .rx_rst_o   (rx_rst_o),
  .tx_rst_o   (tx_rst_o),
  .break_o    (break_o),
  .thr_wr_o   (thr_wr_o),
  .thr_data_o (thr_data_o)
);

// File: tb/duart_regfile_test.sv
module duart_regfile_test;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam int NV  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [15:0] rx_data = '0;
  logic [1:0] rx_rdy = '0, ffull = '0, tx_rdy = '0, tx_emp = '0;
  logic [1:0] ovr = '0, par = '0, frm = '0, brk = '0;
  logic [1:0] rx_en, tx_en, rx_rst, tx_rst, brk_o, par_en, par_odd, two_stop, fifo_ext, tx_half;
  logic [1:0] thr_wr, rhr_rd;
  logic [7:0] data_bits, rx_rate, tx_rate;
  logic [5:0] baud_var;
  logic [15:0] thr_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  duart_regfile #(.NCH(NCH), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_rdy_i(rx_rdy),
    .fifo_full_i(ffull), .tx_rdy_i(tx_rdy), .tx_empty_i(tx_emp),
    .ovr_evt_i(ovr), .par_evt_i(par), .frm_evt_i(frm), .brk_evt_i(brk),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_rst_o(rx_rst), .tx_rst_o(tx_rst),
    .break_o(brk_o), .data_bits_o(data_bits), .par_en_o(par_en), .par_odd_o(par_odd),
    .two_stop_o(two_stop), .fifo_ext_o(fifo_ext), .tx_half_o(tx_half),
    .baud_var_o(baud_var), .rx_rate_o(rx_rate), .tx_rate_o(tx_rate),
    .thr_wr_o(thr_wr), .thr_data_o(thr_data), .rhr_rd_o(rhr_rd)
  );

  // vector: {addr[3:0], wdata[7:0], view[2:0], expect[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {4'h2, 8'h05, 3'd0, 8'h03},  // R2 enable both
    {4'h2, 8'h02, 3'd0, 8'h02},  // R2 rx off
    {4'h2, 8'h03, 3'd0, 8'h02},  // R2 on+off: off wins
    {4'h2, 8'h60, 3'd0, 8'h06},  // R3 break on
    {4'h2, 8'h70, 3'd0, 8'h02},  // R3 break off
    {4'h0, 8'h13, 3'd1, 8'h08},  // R5 MR1: 8 bits no parity
    {4'h0, 8'h0F, 3'd1, 8'h18},  // R6 MR2: two stop
    {4'h0, 8'h07, 3'd1, 8'h08},  // R4 pointer stays at MR2
    {4'h2, 8'h10, 3'd1, 8'h08},  // R4 pointer to MR1
    {4'h0, 8'h06, 3'd1, 8'h67},  // R5 7 bits odd
    {4'h2, 8'hB0, 3'd3, 8'h00},  // R4 pointer to MR0
    {4'h0, 8'h1D, 3'd3, 8'h1D},  // R7 MR0 fields
    {4'h0, 8'h03, 3'd1, 8'h28},  // R4 MR0 write advanced to MR1
    {4'h1, 8'hB9, 3'd2, 8'hB9},  // R8 rate nibbles
    {4'hA, 8'h04, 3'd4, 8'h02},  // R1 channel 1 tx on
    {4'hA, 8'h01, 3'd4, 8'h03},  // R1 channel 1 rx on
    {4'h8, 8'h12, 3'd5, 8'h07},  // R1 channel 1 MR1
    {4'h2, 8'h35, 3'd0, 8'h01},  // R12 tx reset beats tx enable
    {4'h2, 8'h0A, 3'd0, 8'h00},  // R2 both off
    {4'h2, 8'h05, 3'd5, 8'h07}   // R1 channel 0 write leaves channel 1
  };

  function automatic logic [7:0] view(input logic [2:0] s);
    case (s)
      3'd0: view = {5'b0, brk_o[0], tx_en[0], rx_en[0]};
      3'd1: view = {1'b0, par_odd[0], par_en[0], two_stop[0], data_bits[3:0]};
      3'd2: view = {rx_rate[3:0], tx_rate[3:0]};
      3'd3: view = {3'b0, tx_half[0], fifo_ext[0], baud_var[2:0]};
      3'd4: view = {5'b0, brk_o[1], tx_en[1], rx_en[1]};
      default: view = {1'b0, par_odd[1], par_en[1], two_stop[1], data_bits[7:4]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14", view(3'd0), 8'h00);
    chk("R14", view(3'd1), 8'h25);
    chk("R14", view(3'd2), 8'h00);
    rd_reg(4'h1, v); chk("R14", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][22:19], VEC[i][18:11]);
      chk($sformatf("vector %0d", i), view(VEC[i][10:8]), VEC[i][7:0]);
    end

    // R9 status layout; channel 0 has both enables on
    rx_rdy[0] = 1'b1; ffull[0] = 1'b1; tx_rdy[0] = 1'b1; tx_emp[0] = 1'b1;
    rd_reg(4'h1, v); chk("R9", v, 8'h0F);
    wr_reg(4'h2, 8'h08);
    rd_reg(4'h1, v); chk("R9 tx ready gated", v, 8'h0B);

    // R11 receiver reset pulse masks receive ready
    wr_reg(4'h2, 8'h20);
    chk("R11 pulse", {7'b0, rx_rst[0]}, 8'h01);
    rd_reg(4'h1, v); chk("R11 mask", v, 8'h0A);
    @(negedge clk);
    chk("R11 pulse end", {7'b0, rx_rst[0]}, 8'h00);
    rd_reg(4'h1, v); chk("R11 unmask", v, 8'h0B);
    rx_rdy = '0; ffull = '0; tx_rdy = '0; tx_emp = '0;

    // R10 sticky errors
    @(negedge clk); ovr[0] = 1'b1;
    @(negedge clk); ovr[0] = 1'b0;
    rd_reg(4'h1, v); chk("R10 overrun set", v, 8'h10);
    repeat (5) @(negedge clk);
    rd_reg(4'h1, v); chk("R10 overrun sticky", v, 8'h10);
    wr_reg(4'h2, 8'h40);
    rd_reg(4'h1, v); chk("R10 clear", v, 8'h00);
    @(negedge clk); brk[0] = 1'b1; par[0] = 1'b1; frm[1] = 1'b1;
    @(negedge clk); brk[0] = 1'b0; par[0] = 1'b0; frm[1] = 1'b0;
    rd_reg(4'h1, v); chk("R10 break+parity", v, 8'hA0);
    rd_reg(4'h9, v); chk("R1 channel 1 framing", v, 8'h40);
    wr_reg(4'h2, 8'h50);
    rd_reg(4'h1, v); chk("R10 break-only clear", v, 8'h20);
    wr_reg(4'h2, 8'h40);
    rd_reg(4'h1, v); chk("R10 clear all", v, 8'h00);
    @(negedge clk);
    addr = 4'h2; wdata = 8'h40; wr = 1'b1; ovr[0] = 1'b1;
    @(negedge clk);
    wr = 1'b0; ovr[0] = 1'b0;
    rd_reg(4'h1, v); chk("R10 event beats clear", v, 8'h10);

    // R13 holding write and receive read
    wr_reg(4'h3, 8'hA5);
    chk("R13 strobe", {6'b0, thr_wr}, 8'h01);
    chk("R13 data", thr_data[7:0], 8'hA5);
    @(negedge clk);
    chk("R13 strobe end", {6'b0, thr_wr}, 8'h00);
    rx_data = 16'h3C5A;
    addr = 4'h3; rd = 1'b1; #1;
    chk("R13 rx data", rdata, 8'h5A);
    chk("R13 rd strobe", {6'b0, rhr_rd}, 8'h01);
    addr = 4'hB; #1;
    chk("R13 rx data ch1", rdata, 8'h3C);
    chk("R13 rd strobe ch1", {6'b0, rhr_rd}, 8'h02);
    rd = 1'b0;

    // R4 readback through the pointer
    wr_reg(4'h2, 8'hB0);
    rd_reg(4'h0, v); chk("R4 read MR0", v, 8'h1D);
    rd_reg(4'h0, v); chk("R4 read no advance", v, 8'h1D);
    wr_reg(4'h0, 8'h1D);
    rd_reg(4'h0, v); chk("R4 read MR1", v, 8'h03);

    // R12 transmitter reset pulse
    wr_reg(4'h2, 8'h04);
    wr_reg(4'h2, 8'h30);
    chk("R12 pulse", {6'b0, tx_rst}, 8'h01);
    chk("R12 tx off", {7'b0, tx_en[0]}, 8'h00);
    @(negedge clk);
    chk("R12 pulse end", {6'b0, tx_rst}, 8'h00);

    finish_run();
  end
endmodule